// File: doc/BRIEF.md
# Multi-Rate Clock Memory Byte

This block turns the system clock into an 8-bit byte of square waves, one wave per bit, each with a fixed period of its own. Control logic reads the bits as flash signals for lamps and as time bases for monitoring. A single prescaler divides the system clock down to a 50 ms base tick. Eight small dividers, one per bit, count base ticks and flip their bit every half-period, so each bit has a 50 % duty cycle.

The set of periods is fixed and not binary. From bit 0 to bit 7 the periods are 0.1, 0.2, 0.4, 0.5, 0.8, 1.0, 1.6 and 2.0 seconds. The system clock frequency is the parameter `CLK_HZ` and must be an exact multiple of 20 Hz. When the block is in reset or disabled, every bit reads 0 and every divider goes back to its start, so all waves start together in phase once the block is enabled.

Top module: `clk_mem_byte`

## Requirements
- R1: Bit 0 has a period of 0.1 s. It toggles on every base tick, so it first reads 1 after one tick.
- R2: Bits 1, 2 and 3 have periods of 0.2 s, 0.4 s and 0.5 s. They toggle every 2, 4 and 5 base ticks.
- R3: Bits 4, 5 and 6 have periods of 0.8 s, 1.0 s and 1.6 s. They toggle every 8, 10 and 16 base ticks.
- R4: Bit 7 has a period of 2.0 s. It toggles every 20 base ticks.
- R5: Every bit has a 50 % duty cycle and starts at 0. After n enabled clock edges, bit i equals floor(n / (CLK_HZ/20 * Hi)) mod 2, where Hi is the bit's half-period in ticks.
- R6: One base tick occurs every CLK_HZ/20 enabled clock cycles. The byte changes only on a base tick.
- R7: Dropping `en` clears every bit to 0 on the next clock edge and restarts the prescaler and all dividers.
- R8: Synchronous reset clears every bit to 0 and takes priority over `en`.
- R9: While `en` is low the byte stays 0 and no counting goes on. When `en` is raised again, the byte follows the same sequence as after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the byte cleared |
| clk_byte | output | 8 | Square-wave byte, bit 0 fastest |

## Verification
On every cycle the assertions check four things. The byte clears on the edge after `en` drops. The byte holds between base ticks. Bit 0 flips on every tick. The prescaler stays in its range. Only the bench scenarios can show that each bit has the right period and phase: the bench checks the exact byte value at chosen edge counts and on every edge across a full 2 s frame. The same is true of the fresh restart after a disable or a reset in the middle of a run.

// File: rtl/clk_mem_byte.sv
module clk_mem_byte #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [7:0] clk_byte
);

  localparam int unsigned TICK_DIV = CLK_HZ / 20;
  localparam int unsigned PW = ($clog2(TICK_DIV) > 0) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned NBITS = 8;

  function automatic int unsigned half_ticks(input int unsigned idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 5;
      4: return 8;
      5: return 10;
      6: return 16;
      default: return 20;
    endcase
  endfunction

  logic [PW-1:0] pre_cnt;
  logic          tick;
  logic          idle;

  assign idle = rst || !en;
  assign tick = en && (pre_cnt == PW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (idle || tick) pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + 1'b1;
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    localparam logic [4:0] LAST = 5'(half_ticks(i) - 1);
    logic [4:0] div_cnt;
    logic       wave;

    always_ff @(posedge clk) begin
      if (idle) begin
        div_cnt <= '0;
        wave    <= 1'b0;
      end else if (tick) begin
        if (div_cnt == LAST) begin
          div_cnt <= '0;
          wave    <= ~wave;
        end else begin
          div_cnt <= div_cnt + 5'd1;
        end
      end
    end

    assign clk_byte[i] = wave;
  end

  initial AST_RATE_MULTIPLE: assert (CLK_HZ >= 20 && CLK_HZ % 20 == 0); // R6

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en |=> clk_byte == 8'h00); // R7

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(clk_byte)); // R6

  AST_FASTEST_EVERY_TICK: assert property (@(posedge clk) disable iff (rst)
    tick |=> clk_byte[0] != $past(clk_byte[0])); // R1

  AST_PRESCALER_RANGE: assert property (@(posedge clk) disable iff (rst)
    pre_cnt < PW'(TICK_DIV)); // R6

endmodule

// File: tb/clk_mem_byte_tb.sv
module clk_mem_byte_tb;
  localparam int unsigned CLK_HZ = 200;
  localparam int unsigned D = CLK_HZ / 20;
  localparam int NV = 12;

  localparam int unsigned VEC_N [NV] = '{9, 10, 20, 40, 50, 80, 100, 160, 200, 399, 400, 800};
  localparam logic [7:0]  VEC_B [NV] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h0D, 8'h18,
                                         8'h32, 8'h68, 8'hC4, 8'hAF, 8'h10, 8'h40};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] clk_byte;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_mem_byte #(.CLK_HZ(CLK_HZ)) u_dut (.clk(clk), .rst(rst), .en(en), .clk_byte(clk_byte));

  function automatic int unsigned half_of(input int b);
    int unsigned per_ms [8] = '{100, 200, 400, 500, 800, 1000, 1600, 2000};
    return per_ms[b] / 2 / 50;
  endfunction

  function automatic logic [7:0] model(input int unsigned n);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = ((n / (D * half_of(b))) % 2) == 1;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (clk_byte !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, clk_byte, exp);
    end
  endtask

  task automatic edges(input int k);
    for (int j = 0; j < k; j++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic restart();
    rst = 1'b1; en = 1'b0;
    edges(2);
    rst = 1'b0; en = 1'b1;
  endtask

  initial begin
    int unsigned at;
    @(negedge clk);
    edges(2);
    check("R8 reset state", 8'h00);

    restart();
    at = 0;
    for (int v = 0; v < NV; v++) begin
      edges(VEC_N[v] - at);
      at = VEC_N[v];
      check("R1 R2 R3 R4 R5 vector", VEC_B[v]);
    end

    restart();
    for (int unsigned n = 1; n <= 40 * D; n++) begin
      edges(1);
      check("R5 R6 sweep", model(n));
    end

    restart();
    edges(50);
    check("R2 before disable", 8'h0D);
    en = 1'b0;
    edges(1);
    check("R7 disable clears", 8'h00);
    edges(30);
    check("R9 held while disabled", 8'h00);
    en = 1'b1;
    edges(9);
    check("R9 no early tick after enable", 8'h00);
    edges(1);
    check("R9 fresh first tick", 8'h01);
    edges(40);
    check("R9 fresh sequence", 8'h0D);

    rst = 1'b1;
    edges(1);
    check("R8 reset over enable", 8'h00);
    edges(20);
    check("R8 held in reset", 8'h00);
    rst = 1'b0;
    edges(200);
    check("R4 after reset release", 8'hC4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule